// File: doc/BRIEF.md
# Multi-Slot Host Doorbell Scheduler

This block lets many host software threads pass work to an accelerator without any lock between them. A buffer in host memory is cut into equal slots, and each slot belongs to exactly one thread. A thread writes its payload into its own slot and then rings that slot's doorbell. Ringing means setting the slot's full flag, which arrives here as a one-cycle set pulse carrying the slot index. The block keeps one pending bit per slot and chooses ready slots in rotating order. It fetches each chosen slot's payload one word at a time through a request/response read port and streams the words to the application, tagged with the slot index. When the final word has been taken, it emits a flag-clear write for that slot.

Slot addresses come from a base pointer input. Slot `s`, word `w` lives at `base_addr + s*SLOT_BYTES + w*WORD_BYTES`. The block serves one slot at a time and keeps at most one read in flight. A doorbell rung for a slot that is currently being served is kept as a fresh pending bit, so that slot is served again later. An idle output reports that nothing is pending and nothing is in service.

Top module: `slot_doorbell`

## Requirements
- R1: After reset, `idle` is 1 and `rd_req_valid`, `wk_valid` and `clr_valid` are 0.
- R2: A set pulse marks the slot pending. Further set pulses to a slot that is already pending (not yet in service) have no effect, so the slot is served exactly once.
- R3: With the defaults (4 words of 32 bits, so `SLOT_BYTES` = 16 and `WORD_BYTES` = 4), a served slot `s` issues exactly 4 reads, at `base_addr + s*16 + w*4` for w = 0,1,2,3, in that order.
- R4: Each read response is delivered as one work beat carrying the data and `wk_slot` = s. `wk_last` is 1 on the fourth beat only.
- R5: The next slot served is the lowest pending index above the last one served, wrapping from 63 to 0. After reset the search starts at slot 0.
- R6: `clr_valid` pulses for one cycle, with `clr_idx` = s, in the cycle after the last beat of slot `s` is accepted, and at no other time.
- R7: A set pulse for the slot currently in service is recorded, and that slot is served again later in rotating order.
- R8: `rd_req_valid`/`rd_req_addr` and `wk_valid`/`wk_data`/`wk_slot`/`wk_last` hold steady until accepted. Back-pressure on either side loses and duplicates no word.
- R9: `idle` is 1 exactly when no slot is pending and no slot is in service.
- R10: At most one of `rd_req_valid`, `wk_valid` and `clr_valid` is high in any cycle, so at most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | ADDR_W | Byte address of slot 0 |
| set_valid | input | 1 | Doorbell set pulse |
| set_idx | input | IDX_W | Slot being rung |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | DATA_W | Read response data |
| wk_valid | output | 1 | Work beat valid |
| wk_ready | input | 1 | Work beat accepted |
| wk_data | output | DATA_W | Payload word |
| wk_slot | output | IDX_W | Slot the word came from |
| wk_last | output | 1 | Final word of the slot |
| clr_valid | output | 1 | Flag-clear write strobe |
| clr_idx | output | IDX_W | Slot whose flag is cleared |
| idle | output | 1 | Nothing pending or in service |

## Verification
The assertions assume that the read port returns exactly one response for each accepted request, arriving in a later cycle. They also assume that `base_addr` does not change while a slot is in service. The bench's memory model replies exactly one cycle after each accepted request and changes the base only while the block is idle. Ready signals come from a fixed pseudo-random sequence or are held low on purpose. Doorbells are rung either while service is stalled or faster than service proceeds, which makes the serving order predictable arithmetically.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2,
    FS_SEND = 2'd3
  } fetch_state_e;
endpackage

// File: rtl/doorbell_flag_bank.sv
module doorbell_flag_bank #(
  parameter  int NUM_SLOTS = 64,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_valid,
  input  logic [IDX_W-1:0]     set_idx,
  input  logic                 take_valid,
  input  logic [IDX_W-1:0]     take_idx,
  output logic [NUM_SLOTS-1:0] pend
);
  // One pending bit per slot; a set in the same cycle as a take wins,
  // so a doorbell rung while the slot is picked is not lost.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit_set, hit_take;
    assign hit_set  = set_valid  && (set_idx  == IDX_W'(g));
    assign hit_take = take_valid && (take_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst)           pend[g] <= 1'b0;
      else if (hit_set)  pend[g] <= 1'b1;
      else if (hit_take) pend[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/doorbell_rr_pick.sv
module doorbell_rr_pick #(
  parameter  int NUM_SLOTS = 64,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] req,
  input  logic [IDX_W-1:0]     last_idx,
  output logic                 pick_valid,
  output logic [IDX_W-1:0]     pick_idx
);
  logic [NUM_SLOTS-1:0] above;
  logic [NUM_SLOTS-1:0] masked;

  function automatic logic [IDX_W-1:0] lowest(input logic [NUM_SLOTS-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mask
    assign above[g] = (IDX_W'(g) > last_idx);
  end

  assign masked     = req & above;
  assign pick_valid = |req;
  assign pick_idx   = (|masked) ? lowest(masked) : lowest(req);
endmodule

// File: rtl/doorbell_fetch.sv
module doorbell_fetch #(
  parameter  int NUM_SLOTS = 64,
  parameter  int ADDR_W    = 32,
  parameter  int DATA_W    = 32,
  parameter  int WORDS     = 4,
  localparam int IDX_W      = $clog2(NUM_SLOTS),
  localparam int WRD_W      = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int SLOT_BYTES = WORDS * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              pick_valid,
  input  logic [IDX_W-1:0]  pick_idx,
  output logic              take_valid,
  output logic [IDX_W-1:0]  last_idx,
  output logic              busy,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              wk_valid,
  input  logic              wk_ready,
  output logic [DATA_W-1:0] wk_data,
  output logic [IDX_W-1:0]  wk_slot,
  output logic              wk_last,
  output logic              clr_valid,
  output logic [IDX_W-1:0]  clr_idx
);
  import doorbell_pkg::*;

  localparam logic [WRD_W-1:0] LAST_WORD = WRD_W'(WORDS - 1);

  fetch_state_e     state_q;
  logic [IDX_W-1:0] slot_q;
  logic [WRD_W-1:0] word_q;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [IDX_W-1:0]  s,
                                                  input logic [WRD_W-1:0]  w);
    return b + ADDR_W'(s) * ADDR_W'(SLOT_BYTES) + ADDR_W'(w) * ADDR_W'(WORD_BYTES);
  endfunction

  assign take_valid = (state_q == FS_IDLE) && pick_valid;
  assign busy       = (state_q != FS_IDLE);
  assign wk_slot    = slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= FS_IDLE;
      slot_q       <= '0;
      word_q       <= '0;
      last_idx     <= '1;
      rd_req_valid <= 1'b0;
      rd_req_addr  <= '0;
      wk_valid     <= 1'b0;
      wk_data      <= '0;
      wk_last      <= 1'b0;
      clr_valid    <= 1'b0;
      clr_idx      <= '0;
    end else begin
      clr_valid <= 1'b0;
      unique case (state_q)
        FS_IDLE: begin
          if (pick_valid) begin
            slot_q       <= pick_idx;
            last_idx     <= pick_idx;
            word_q       <= '0;
            rd_req_valid <= 1'b1;
            rd_req_addr  <= word_addr(base_addr, pick_idx, '0);
            state_q      <= FS_REQ;
          end
        end
        FS_REQ: begin
          if (rd_req_ready) begin
            rd_req_valid <= 1'b0;
            state_q      <= FS_WAIT;
          end
        end
        FS_WAIT: begin
          if (rd_rsp_valid) begin
            wk_valid <= 1'b1;
            wk_data  <= rd_rsp_data;
            wk_last  <= (word_q == LAST_WORD);
            state_q  <= FS_SEND;
          end
        end
        FS_SEND: begin
          if (wk_ready) begin
            wk_valid <= 1'b0;
            if (wk_last) begin
              clr_valid <= 1'b1;
              clr_idx   <= slot_q;
              state_q   <= FS_IDLE;
            end else begin
              word_q       <= word_q + 1'b1;
              rd_req_valid <= 1'b1;
              rd_req_addr  <= word_addr(base_addr, slot_q, word_q + 1'b1);
              state_q      <= FS_REQ;
            end
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_doorbell.sv
module slot_doorbell #(
  parameter  int NUM_SLOTS = 64,
  parameter  int ADDR_W    = 32,
  parameter  int DATA_W    = 32,
  parameter  int WORDS     = 4,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              set_valid,
  input  logic [IDX_W-1:0]  set_idx,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              wk_valid,
  input  logic              wk_ready,
  output logic [DATA_W-1:0] wk_data,
  output logic [IDX_W-1:0]  wk_slot,
  output logic              wk_last,
  output logic              clr_valid,
  output logic [IDX_W-1:0]  clr_idx,
  output logic              idle
);
  logic [NUM_SLOTS-1:0] pend;
  logic                 pick_valid;
  logic [IDX_W-1:0]     pick_idx;
  logic                 take_valid;
  logic [IDX_W-1:0]     last_idx;
  logic                 busy;

  doorbell_flag_bank #(.NUM_SLOTS(NUM_SLOTS)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .set_valid  (set_valid),
    .set_idx    (set_idx),
    .take_valid (take_valid),
    .take_idx   (pick_idx),
    .pend       (pend)
  );

  doorbell_rr_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .req        (pend),
    .last_idx   (last_idx),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  doorbell_fetch #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WORDS     (WORDS)
  ) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .base_addr    (base_addr),
    .pick_valid   (pick_valid),
    .pick_idx     (pick_idx),
    .take_valid   (take_valid),
    .last_idx     (last_idx),
    .busy         (busy),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .wk_valid     (wk_valid),
    .wk_ready     (wk_ready),
    .wk_data      (wk_data),
    .wk_slot      (wk_slot),
    .wk_last      (wk_last),
    .clr_valid    (clr_valid),
    .clr_idx      (clr_idx)
  );

  // Derived only from registers: no path from any input to idle.
  assign idle = ~(|pend) && !busy;
endmodule

// File: rtl/slot_doorbell_chk.sv
module slot_doorbell_chk #(
  parameter  int NUM_SLOTS = 64,
  parameter  int ADDR_W    = 32,
  parameter  int DATA_W    = 32,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              wk_valid,
  input logic              wk_ready,
  input logic [DATA_W-1:0] wk_data,
  input logic [IDX_W-1:0]  wk_slot,
  input logic              wk_last,
  input logic              clr_valid,
  input logic [IDX_W-1:0]  clr_idx,
  input logic              idle
);
  a_r8_wk_hold: assert property (@(posedge clk) disable iff (rst)
    wk_valid && !wk_ready |=> wk_valid && $stable(wk_data) && $stable(wk_slot) && $stable(wk_last));

  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  a_r6_clr_after_last: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> $past(wk_valid && wk_ready && wk_last));

  a_r6_clr_index: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> clr_idx == $past(wk_slot));

  a_r10_one_activity: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_req_valid, wk_valid, clr_valid}));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    idle |-> !rd_req_valid && !wk_valid);

  // Input assumption behind R10: a response only answers an accepted request.
  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    rd_rsp_valid |-> $past(rd_req_valid && rd_req_ready));
endmodule

bind slot_doorbell slot_doorbell_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_valid (rd_rsp_valid),
  .wk_valid     (wk_valid),
  .wk_ready     (wk_ready),
  .wk_data      (wk_data),
  .wk_slot      (wk_slot),
  .wk_last      (wk_last),
  .clr_valid    (clr_valid),
  .clr_idx      (clr_idx),
  .idle         (idle)
);

// File: tb/slot_doorbell_tb.sv
module slot_doorbell_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 64;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int NW  = 4;
  localparam int IW  = 6;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] base_addr = 32'h0001_0000;
  logic          set_valid = 1'b0;
  logic [IW-1:0] set_idx = '0;
  logic          rd_req_valid;
  logic          rd_req_ready = 1'b1;
  logic [AW-1:0] rd_req_addr;
  logic          rd_rsp_valid = 1'b0;
  logic [DW-1:0] rd_rsp_data = '0;
  logic          wk_valid;
  logic          wk_ready = 1'b1;
  logic [DW-1:0] wk_data;
  logic [IW-1:0] wk_slot;
  logic          wk_last;
  logic          clr_valid;
  logic [IW-1:0] clr_idx;
  logic          idle;

  int  errs = 0;
  int  checks = 0;
  int  cycles = 0;
  bit  hold_wk = 0;
  bit  rand_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  int served [0:511];
  int served_n = 0;
  int beat = 0;
  int cur_slot = -1;
  bit expect_clr = 0;
  int clr_exp_idx = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  slot_doorbell #(.NUM_SLOTS(NS), .ADDR_W(AW), .DATA_W(DW), .WORDS(NW)) u_dut (
    .clk(clk), .rst(rst), .base_addr(base_addr),
    .set_valid(set_valid), .set_idx(set_idx),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wk_valid(wk_valid), .wk_ready(wk_ready), .wk_data(wk_data),
    .wk_slot(wk_slot), .wk_last(wk_last),
    .clr_valid(clr_valid), .clr_idx(clr_idx), .idle(idle)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Memory model (one-cycle response) and ready generation.
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_req_ready <= rand_mode ? lfsr[1] : 1'b1;
    wk_ready     <= hold_wk ? 1'b0 : (rand_mode ? lfsr[4] : 1'b1);
    if (rst) rd_rsp_valid <= 1'b0;
    else begin
      rd_rsp_valid <= rd_req_valid && rd_req_ready;
      rd_rsp_data  <= mem_word(rd_req_addr);
    end
  end

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (expect_clr) begin
        check(clr_valid == 1'b1, "R6 clr pulse", int'(clr_valid), 1);
        check(int'(clr_idx) == clr_exp_idx, "R6 clr index", int'(clr_idx), clr_exp_idx);
        expect_clr = 0;
      end else if (clr_valid) begin
        check(1'b0, "R6 stray clr", int'(clr_idx), -1);
      end
      if (wk_valid && wk_ready) begin
        if (beat == 0) cur_slot = int'(wk_slot);
        check(int'(wk_slot) == cur_slot, "R4 slot tag", int'(wk_slot), cur_slot);
        check(wk_data == mem_word(base_addr + 32'(cur_slot) * 16 + 32'(beat) * 4),
              "R3 address/data", int'(wk_data),
              int'(mem_word(base_addr + 32'(cur_slot) * 16 + 32'(beat) * 4)));
        check(wk_last == (beat == NW - 1), "R4 last flag", int'(wk_last), int'(beat == NW - 1));
        check(!rd_req_valid, "R10 single activity", int'(rd_req_valid), 0);
        if (beat == NW - 1) begin
          served[served_n] = cur_slot;
          served_n++;
          expect_clr = 1;
          clr_exp_idx = cur_slot;
          beat = 0;
        end else begin
          beat++;
        end
      end
    end
  end

  task automatic ring(input int s);
    @(posedge clk); #1;
    set_valid = 1'b1;
    set_idx   = IW'(s);
    @(posedge clk); #1;
    set_valid = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (idle) break;
    end
    wait_cycles(3);
  endtask

  task automatic check_seq(input int first, input int n, input int exp [0:63], input string req);
    check(served_n - first == n, {req, " served count"}, served_n - first, n);
    for (int i = 0; i < n; i++)
      check(served[first + i] == exp[i], req, served[first + i], exp[i]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int exp [0:63];
    int first;

    wait_cycles(4);
    @(negedge clk);
    // R1: state during reset settles to idle with nothing valid
    rst = 1'b0;
    @(negedge clk);
    check(idle == 1'b1, "R1 idle after reset", int'(idle), 1);
    check(!rd_req_valid && !wk_valid && !clr_valid, "R1 outputs quiet",
          int'({rd_req_valid, wk_valid, clr_valid}), 0);

    // T1 (R5): ring all slots in order, expect 0..63
    first = served_n;
    for (int s = 0; s < NS; s++) ring(s);
    wait_idle();
    for (int i = 0; i < NS; i++) exp[i] = i;
    check_seq(first, NS, exp, "R5 full sweep order");
    check(idle == 1'b1, "R9 idle after drain", int'(idle), 1);

    // T2 (R5 wrap, R9): stall on 40, then ring 5, 2, 63, 41
    first = served_n;
    hold_wk = 1;
    ring(40);
    wait_cycles(10);
    ring(5); ring(2); ring(63); ring(41);
    wait_cycles(5);
    @(negedge clk);
    check(idle == 1'b0, "R9 busy while pending", int'(idle), 0);
    #1 hold_wk = 0;
    wait_idle();
    exp[0] = 40; exp[1] = 41; exp[2] = 63; exp[3] = 2; exp[4] = 5;
    check_seq(first, 5, exp, "R5 wrap order");

    // T3 (R7): re-ring slot 10 during its service, new base
    base_addr = 32'h8000_0F00;
    first = served_n;
    hold_wk = 1;
    ring(10);
    wait_cycles(10);
    ring(10); ring(12);
    wait_cycles(3);
    hold_wk = 0;
    wait_idle();
    exp[0] = 10; exp[1] = 12; exp[2] = 10;
    check_seq(first, 3, exp, "R7 re-ring served again");

    // T4 (R2): repeated rings of a pending slot are served once
    first = served_n;
    hold_wk = 1;
    ring(20);
    wait_cycles(10);
    ring(30); ring(30); ring(30);
    wait_cycles(3);
    hold_wk = 0;
    wait_idle();
    exp[0] = 20; exp[1] = 30;
    check_seq(first, 2, exp, "R2 duplicate ring");

    // T5 (R8): random back-pressure on both sides
    base_addr = 32'h0000_4000;
    rand_mode = 1;
    first = served_n;
    for (int s = 0; s < NS; s += 3) ring(s);
    wait_idle();
    for (int i = 0; i < 22; i++) exp[i] = 3 * i;
    check_seq(first, 22, exp, "R8 back-pressure order");
    rand_mode = 0;

    // T6 (R8): random back-pressure, every slot, rung in reverse
    first = served_n;
    rand_mode = 1;
    hold_wk = 1;
    for (int s = NS - 1; s >= 0; s--) ring(s);
    #1 hold_wk = 0;
    wait_idle();
    rand_mode = 0;
    // last served was 63, so service wraps: 63 picked first, then 0..62
    exp[0] = 63;
    for (int i = 1; i < NS; i++) exp[i] = i - 1;
    check_seq(first, NS, exp, "R8 reverse ring order");
    check(idle == 1'b1, "R9 idle at end", int'(idle), 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule